// File: doc/BRIEF.md
# Channel-Programmed Dual-Modulus Synthesizer Divider

This block holds the digital dividers of an integer-N frequency synthesizer for a ten-channel narrow-band receiver. A reference divider turns the 4 MHz system clock into a 5 kHz comparison pulse train. A feedback divider counts the output edges of an external 64/65 dual-modulus prescaler. It drives the prescaler's modulus-control line so that one feedback pulse marks exactly N VCO cycles. N is the ratio of the selected channel.

The channel comes from one of two 4-bit sources. One is a parallel code from switches, which read as 1 when left open. The other is an index delivered by a separate pulse-width decoder. The source is chosen by a select input. The channel is decoded, defaulted when out of range and looked up in a ratio table. The ratio is split into a main count B and a swallow count A, which are loaded at every feedback reload. A new channel therefore never shortens a feedback cycle that is already running. A high level on the active-low enable puts both dividers in standby.

Top module: `chan_synth_div`

## Requirements
- R1: With the block enabled, `ref_pulse` is high for exactly one cycle every 800 clock cycles. The first pulse follows the 800th active clock edge after enable is asserted.
- R2: For channel n, one feedback frame covers a sum of prescaler moduli (64 or 65 per `pre_tick`) equal to 5306 + 6·(n−1). So channel 1 gives 5306 and channel 10 gives 5360. `fb_pulse` is high for one cycle, in the cycle after the final tick of the frame.
- R3: A frame consists of B = ratio/64 ticks (integer part). `mod_sel` is 1 (divide by 65) for the first A = ratio mod 64 ticks and 0 for the rest. Ratio 5312 (channel 2) has A = 0, so `mod_sel` stays 0 for the whole frame. `mod_sel` changes only on a tick, a reload or in standby.
- R4: With `src_sel` = 0, the channel is `par_code` read as an unsigned binary number, bit 3 most significant, valid from 1 to 10.
- R5: A selected code of 0 or of 11 to 15 selects channel 10. This covers all inputs open (4'b1111) and all grounded (4'b0000), and it applies to both sources.
- R6: With `src_sel` = 1, the channel is `idx_code`, decoded in the same binary form, and `par_code` has no effect.
- R7: A channel change reaches the counters only at the next reload. The frame in progress completes with its old ratio, and the next frame uses the new one.
- R8: While `en_n` is high, both pulse outputs stay low and the counters keep reloading the current ratio. After `en_n` falls, the first frame is a full frame of the selected ratio.
- R9: A synchronous `rst` forces the channel to 10, clears both pulse outputs and loads the channel-10 ratio (A = 48), so `mod_sel` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable; high holds both dividers (standby) |
| src_sel | input | 1 | Channel source: 0 parallel code, 1 decoded index |
| par_code | input | 4 | Parallel channel code (1 = open, 0 = grounded) |
| idx_code | input | 4 | Channel index from the pulse decoder |
| pre_tick | input | 1 | One-cycle strobe per prescaler output edge |
| ref_pulse | output | 1 | 5 kHz reference comparison pulse |
| fb_pulse | output | 1 | Feedback pulse, one per N VCO cycles |
| mod_sel | output | 1 | Prescaler modulus control: 1 divide by 65, 0 divide by 64 |

## Verification
`fb_pulse` appears in the cycle after the clock edge that takes the final tick of a frame. `ref_pulse` appears after the 800th edge following enable. A code change passes two register stages before the counters can load it. The bench samples every output on the falling edge and adds up the modulus for each tick it issues. At each feedback pulse it compares the sum, the tick count and the number of divide-by-65 ticks against the ratio recorded when that frame began. Channel changes are applied either right after a reload or hundreds of cycles before the next one, so every frame's expected ratio is unambiguous.

// File: rtl/chsyn_pkg.sv
package chsyn_pkg;
  parameter int CODE_W = 4;
  typedef logic [CODE_W-1:0] chan_code_t;

  function automatic logic code_in_range(chan_code_t c, int unsigned nch);
    return (c != '0) && (int'(c) <= int'(nch));
  endfunction
endpackage

// File: rtl/chsyn_chan_select.sv
module chsyn_chan_select
  import chsyn_pkg::*;
#(
  parameter int NCH    = 10,
  parameter int DEF_CH = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_sel,
  input  chan_code_t par_code,
  input  chan_code_t idx_code,
  output chan_code_t chan_q
);
  localparam chan_code_t DEF_C = CODE_W'(DEF_CH);

  chan_code_t picked;

  always_comb begin
    picked = src_sel ? idx_code : par_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= DEF_C;
    end else if (code_in_range(picked, NCH)) begin
      chan_q <= picked;
    end else begin
      chan_q <= DEF_C;
    end
  end
endmodule

// File: rtl/chsyn_ratio_table.sv
module chsyn_ratio_table
  import chsyn_pkg::*;
#(
  parameter int NCH     = 10,
  parameter int DEF_CH  = 10,
  parameter int BASE    = 5306,
  parameter int STEP    = 6,
  parameter int RATIO_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  chan_code_t         chan,
  output logic [RATIO_W-1:0] ratio_q
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [RATIO_W-1:0] DEF_RATIO = RATIO_W'(BASE + STEP * (DEF_CH - 1));

  logic [RATIO_W-1:0] rom [NCH];
  logic [IDX_W-1:0]   rd_idx;

  initial begin
    for (int i = 0; i < NCH; i++) begin
      rom[i] = RATIO_W'(BASE + STEP * i);
    end
  end

  always_comb begin
    rd_idx = IDX_W'(chan - CODE_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= DEF_RATIO;
    end else begin
      ratio_q <= rom[rd_idx];
    end
  end
endmodule

// File: rtl/chsyn_ref_divider.sv
module chsyn_ref_divider #(
  parameter int REF_DIV = 800
) (
  input  logic clk,
  input  logic hold,
  output logic pulse
);
  localparam int CNT_W = $clog2(REF_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/chsyn_swallow_divider.sv
module chsyn_swallow_divider #(
  parameter int RATIO_W = 13,
  parameter int PS_BITS = 6
) (
  input  logic               clk,
  input  logic               hold,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               mod_q,
  output logic               fb_q
);
  localparam int B_W = RATIO_W - PS_BITS;

  logic [B_W-1:0]     b_cnt;
  logic [PS_BITS-1:0] a_cnt;
  logic [B_W-1:0]     b_load;
  logic [PS_BITS-1:0] a_load;

  always_comb begin
    b_load = ratio[RATIO_W-1:PS_BITS];
    a_load = ratio[PS_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      b_cnt <= b_load;
      a_cnt <= a_load;
      mod_q <= (a_load != '0);
      fb_q  <= 1'b0;
    end else begin
      fb_q <= 1'b0;
      if (tick) begin
        if (b_cnt == B_W'(1)) begin
          b_cnt <= b_load;
          a_cnt <= a_load;
          mod_q <= (a_load != '0);
          fb_q  <= 1'b1;
        end else begin
          b_cnt <= b_cnt - 1'b1;
          if (a_cnt != '0) begin
            a_cnt <= a_cnt - 1'b1;
            mod_q <= (a_cnt != PS_BITS'(1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/chan_synth_div.sv
module chan_synth_div #(
  parameter int REF_DIV      = 800,
  parameter int PRESCALE_LOW = 64,
  parameter int NCH          = 10,
  parameter int DEF_CH       = 10,
  parameter int BASE_RATIO   = 5306,
  parameter int RATIO_STEP   = 6,
  parameter int RATIO_W      = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_n,
  input  logic       src_sel,
  input  logic [3:0] par_code,
  input  logic [3:0] idx_code,
  input  logic       pre_tick,
  output logic       ref_pulse,
  output logic       fb_pulse,
  output logic       mod_sel
);
  import chsyn_pkg::*;

  localparam int PS_BITS = $clog2(PRESCALE_LOW);

  logic               hold;
  chan_code_t         chan_q;
  logic [RATIO_W-1:0] ratio_q;

  always_comb begin
    hold = rst | en_n;
  end

  chsyn_chan_select #(
    .NCH    (NCH),
    .DEF_CH (DEF_CH)
  ) u_sel (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel),
    .par_code (par_code),
    .idx_code (idx_code),
    .chan_q   (chan_q)
  );

  chsyn_ratio_table #(
    .NCH     (NCH),
    .DEF_CH  (DEF_CH),
    .BASE    (BASE_RATIO),
    .STEP    (RATIO_STEP),
    .RATIO_W (RATIO_W)
  ) u_tab (
    .clk     (clk),
    .rst     (rst),
    .chan    (chan_q),
    .ratio_q (ratio_q)
  );

  chsyn_ref_divider #(
    .REF_DIV (REF_DIV)
  ) u_ref (
    .clk   (clk),
    .hold  (hold),
    .pulse (ref_pulse)
  );

  chsyn_swallow_divider #(
    .RATIO_W (RATIO_W),
    .PS_BITS (PS_BITS)
  ) u_fb (
    .clk   (clk),
    .hold  (hold),
    .tick  (pre_tick),
    .ratio (ratio_q),
    .mod_q (mod_sel),
    .fb_q  (fb_pulse)
  );
endmodule

// File: rtl/chan_synth_div_chk.sv
module chan_synth_div_chk (
  input logic clk,
  input logic rst,
  input logic en_n,
  input logic pre_tick,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic mod_sel
);
  // R8
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (!ref_pulse && !fb_pulse));

  // R1
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R2
  fb_single_chk: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R3
  mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pre_tick && !en_n) |=> $stable(mod_sel));

  // R3
  mod_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_sel) |-> (fb_pulse || $past(en_n) || $past(rst)));
endmodule

bind chan_synth_div chan_synth_div_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_n      (en_n),
  .pre_tick  (pre_tick),
  .ref_pulse (ref_pulse),
  .fb_pulse  (fb_pulse),
  .mod_sel   (mod_sel)
);

// File: tb/sim_chan_synth_div.sv
module sim_chan_synth_div;
  localparam int REF = 800;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       en_n = 1'b1;
  logic       src_sel = 1'b0;
  logic [3:0] par_code = 4'd2;
  logic [3:0] idx_code = 4'd0;
  logic       pre_tick = 1'b0;
  logic       ref_pulse, fb_pulse, mod_sel;

  chan_synth_div u0 (
    .clk(clk), .rst(rst), .en_n(en_n), .src_sel(src_sel),
    .par_code(par_code), .idx_code(idx_code), .pre_tick(pre_tick),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .mod_sel(mod_sel)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  int acc = 0, ticks = 0, t65 = 0, ref_gap = 0, frames = 0, cycles = 0;
  int stby_hits = 0;
  bit run = 1'b0, phase = 1'b0, timed_out = 1'b0;

  function automatic int model_ratio(logic s, logic [3:0] p, logic [3:0] i);
    int c;
    c = s ? int'(i) : int'(p);
    if (c < 1 || c > 10) c = 10;
    return 5306 + 6 * (c - 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_tick();
    acc += mod_sel ? 65 : 64;
    ticks++;
    if (mod_sel) t65++;
  endtask

  // driver side: push the ratio the next frame must realise
  task automatic push_expected();
    exp_q.push_back(model_ratio(src_sel, par_code, idx_code));
  endtask

  task automatic step();
    int e;
    @(negedge clk);
    cycles++;
    if (run) begin
      ref_gap++;
      if (ref_pulse) begin
        check("R1", "reference interval", ref_gap, REF);
        ref_gap = 0;
      end
      if (fb_pulse) begin
        if (exp_q.size() == 0) begin
          check("R2", "unexpected feedback pulse", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check("R2", "VCO cycles per frame", acc, e);
          check("R3", "ticks per frame", ticks, e / 64);
          check("R3", "divide-by-65 ticks", t65, e % 64);
        end
        acc = 0; ticks = 0; t65 = 0;
        frames++;
        push_expected();
      end
    end else if (ref_pulse || fb_pulse) begin
      stby_hits++;
    end
    phase = ~phase;
    pre_tick = phase;
    if (phase && run) count_tick();
  endtask

  task automatic run_frames(int n);
    int target;
    target = frames + n;
    while (frames < target && !timed_out) begin
      step();
      if (cycles > WATCHDOG) begin
        timed_out = 1'b1;
        check("WATCHDOG", "run ended before frames", frames, target);
      end
    end
  endtask

  task automatic leave_standby();
    en_n = 1'b0;
    run = 1'b1;
    exp_q.delete();
    acc = 0; ticks = 0; t65 = 0; ref_gap = 0;
    push_expected();
    if (pre_tick) count_tick();
  endtask

  initial begin
    // R9: reset with channel 2 on the switches still shows channel 10 loaded
    for (int k = 0; k < 5; k++) step();
    check("R9", "fb_pulse in reset", int'(fb_pulse), 0);
    check("R9", "ref_pulse in reset", int'(ref_pulse), 0);
    check("R9", "mod_sel with channel 10 loaded", int'(mod_sel), 1);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) step();
    // R4 / R3: channel 2 (5312, A = 0) loaded in standby
    check("R4", "mod_sel for channel 2 in standby", int'(mod_sel), 0);
    // R5: code 0 defaults to channel 10 (A = 48)
    par_code = 4'd0;
    for (int k = 0; k < 4; k++) step();
    check("R5", "mod_sel for code 0", int'(mod_sel), 1);
    par_code = 4'd2;
    for (int k = 0; k < 4; k++) step();
    check("R8", "pulses during standby", stby_hits, 0);

    // R2/R3/R4: channel 2 then channel 1, changed at a reload (R7)
    leave_standby();
    run_frames(1);
    par_code = 4'd1;
    run_frames(2);
    // R7: mid-frame change to all-open (R5 default 10) leaves this frame at 5306
    for (int k = 0; k < 500; k++) step();
    par_code = 4'b1111;
    run_frames(1);
    // R6: index source, channel 3 (5318); parallel 11 ignored
    src_sel = 1'b1;
    idx_code = 4'd3;
    par_code = 4'd11;
    run_frames(2);
    // R5: index 0 defaults to channel 10
    idx_code = 4'd0;
    run_frames(2);

    // R8: standby in mid-frame, then a full frame of channel 9 and a fresh reference
    for (int k = 0; k < 300; k++) step();
    en_n = 1'b1;
    run = 1'b0;
    stby_hits = 0;
    src_sel = 1'b0;
    par_code = 4'd9;
    for (int k = 0; k < 900; k++) step();
    check("R8", "pulses during standby", stby_hits, 0);
    leave_standby();
    run_frames(1);
    check("R8", "frames seen after standby", (frames > 0) ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule